// File: doc/BRIEF.md
# Transmit Descriptor Gather Engine

This block walks a ring of transmit frame descriptors held in host memory and turns each descriptor into an ordered list of DMA read requests. The ring has 256 slots of 128 bytes, and it starts at an address aligned to 256 bytes. The producer moves a write index forward to hand descriptors over. The engine keeps a read index of its own. When the two indices differ, the engine reads the descriptor at the read index over a synchronous memory port: one 32-bit word per cycle, with the data returned one cycle later. It then decodes the descriptor's scatter entries and emits them one at a time as (36-bit address, 12-bit length) requests on a valid/ready stream. The first request of a frame is marked start-of-frame and the last is marked end-of-frame.

Each descriptor begins with three reserved bytes. A count byte follows, and its five low bits give the number of live entries. After that come twenty 6-byte entries and four bytes of padding. Each entry is a little-endian 32-bit low address followed by a 16-bit word. The four low bits of that word are address bits 35:32 and its twelve upper bits are the buffer length. The engine rejects two kinds of bad descriptor. A descriptor whose entry count is out of range is skipped. A frame whose buffers add up to more than 8192 bytes is cut off at the entry that overflows. In both cases the descriptor is retired and the read index moves on.

The control sequence uses five states:
- IDLE goes to FETCH when the ring is not empty.
- FETCH issues all 32 word reads and goes to CHECK after the last one.
- CHECK goes to RETIRE on a bad count, or to EMIT otherwise.
- EMIT goes to RETIRE when the end-of-frame request is accepted, or when the next entry would overflow the frame limit.
- RETIRE advances the read index and returns to IDLE.

Top module: `tfd_gather_top`

## Requirements
- R1: While reset is asserted, `rd_idx` is 0 and both `req_valid` and `mem_req` are low.
- R2: When `rd_idx` equals `wr_idx`, the ring is empty and no memory read is issued.
- R3: A descriptor is fetched as 32 consecutive word reads with `mem_req` high. Read k of the 32 uses address `ring_base*256 + rd_idx*128 + 4*k`, with k running from 0 to 31 in order. `mem_req` and `req_valid` are never high together.
- R4: The entry count is bits [4:0] of descriptor byte 3, and bits [7:5] of that byte have no effect. Entry e starts at byte 4+6e. Its first four bytes, in little-endian order, give address bits [31:0]. The following little-endian 16-bit word gives address bits [35:32] in its bits [3:0] and the length in its bits [15:4]. Entries are emitted in ascending order, and entries at or beyond the count are never emitted.
- R5: `req_sof` is high only on the request for entry 0, and `req_eof` is high only on the request for the last counted entry.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and the address, length and both markers hold their values.
- R7: A count of 0, or a count above 20, makes `err_count` high for one cycle. No request is emitted for that descriptor, and the descriptor is retired.
- R8: Before an entry is emitted, its length is added to the frame's running total. If the total would exceed 8192, `err_frame` is high for one cycle, that entry and all later entries are not emitted, and the descriptor is retired. A total of exactly 8192 is legal.
- R9: `rd_idx` increases by exactly one, wrapping from 255 to 0. The increase shows two cycles after the cycle in which the end-of-frame request is accepted or an error flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | 28 | Ring base, physical address bits 35:8 |
| wr_idx | input | 8 | Producer write index |
| rd_idx | output | 8 | Engine read index (next descriptor to consume) |
| mem_req | output | 1 | Memory word read strobe |
| mem_addr | output | 36 | Byte address of the word being read |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_req` |
| req_valid | output | 1 | Gather request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 36 | Buffer start address |
| req_len | output | 12 | Buffer length in bytes |
| req_sof | output | 1 | First request of a frame |
| req_eof | output | 1 | Last request of a frame |
| err_count | output | 1 | One-cycle pulse: entry count out of range |
| err_frame | output | 1 | One-cycle pulse: frame length limit exceeded |

## Verification
The bench builds descriptors that exercise each corner case, and checks the outcome a faulty design would get wrong:
- A count byte with junk in bits 7:5: a decoder that used the whole byte would emit too many entries or flag a false error.
- Counts of 0 and 21: an off-by-one range check would either emit from a garbage slot or reject a legal descriptor.
- A 20-entry descriptor: this reaches the top byte offsets, so a wrong entry stride would show up as corrupted addresses.
- Frame totals of 8300 and of exactly 8192: an overflow test that is off by one or misplaced would either truncate a legal frame or emit the offending buffer.

The bench also stalls `req_ready` in a pseudo-random pattern to catch requests that change while stalled. It runs more than a full lap of the ring, so a read index that fails to wrap at 255, or advances at the wrong moment, breaks the fetch address check.

// File: rtl/tfd_gather_pkg.sv
package tfd_gather_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_EMIT,
        ST_RETIRE
    } gather_state_e;

    // Count field: low five bits of descriptor byte 3
    localparam int CNT_FIELD_W    = 5;
    localparam int CNT_FIELD_LSB  = 24;
    // Scatter entry geometry inside the descriptor
    localparam int ENT_FIRST_BYTE = 4;
    localparam int ENT_BYTES      = 6;

endpackage

// File: rtl/tfd_desc_store.sv
module tfd_desc_store #(
    parameter int WORDS = 32,
    parameter int IW    = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_sel,
    input  logic [31:0]          wr_data,
    output logic [WORDS*32-1:0]  flat
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [31:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_sel == IW'(g))) begin
                word_q <= wr_data;
            end
        end

        assign flat[g*32 +: 32] = word_q;
    end

endmodule

// File: rtl/tfd_entry_mux.sv
module tfd_entry_mux
    import tfd_gather_pkg::*;
#(
    parameter int DESC_BITS = 1024,
    parameter int MAX_ENT   = 20,
    parameter int SEL_W     = 5,
    parameter int AW        = 36,
    parameter int LW        = 12
) (
    input  logic [DESC_BITS-1:0]   flat,
    input  logic [SEL_W-1:0]       sel,
    output logic [AW-1:0]          ent_addr,
    output logic [LW-1:0]          ent_len,
    output logic [CNT_FIELD_W-1:0] cnt_field
);

    localparam int HI_W = AW - 32;

    logic [AW-1:0] addr_arr [MAX_ENT];
    logic [LW-1:0] len_arr  [MAX_ENT];

    for (genvar e = 0; e < MAX_ENT; e++) begin : g_ent
        localparam int OFS = 8 * (ENT_FIRST_BYTE + ENT_BYTES * e);
        logic [15:0] hw;
        assign hw          = flat[OFS + 32 +: 16];
        assign addr_arr[e] = {hw[HI_W-1:0], flat[OFS +: 32]};
        assign len_arr[e]  = hw[15 -: LW];
    end

    always_comb begin
        ent_addr = '0;
        ent_len  = '0;
        for (int i = 0; i < MAX_ENT; i++) begin
            if (sel == SEL_W'(i)) begin
                ent_addr = addr_arr[i];
                ent_len  = len_arr[i];
            end
        end
    end

    assign cnt_field = flat[CNT_FIELD_LSB +: CNT_FIELD_W];

endmodule

// File: rtl/tfd_gather_top.sv
module tfd_gather_top
    import tfd_gather_pkg::*;
#(
    parameter int AW         = 36,
    parameter int IDX_W      = 8,
    parameter int DESC_BYTES = 128,
    parameter int MAX_ENT    = 20,
    parameter int LW         = 12,
    parameter int MAX_FRAME  = 8192,
    parameter int BASE_LSB   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-BASE_LSB-1:0] ring_base,
    input  logic [IDX_W-1:0]     wr_idx,
    output logic [IDX_W-1:0]     rd_idx,
    output logic                 mem_req,
    output logic [AW-1:0]        mem_addr,
    input  logic [31:0]          mem_rdata,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [AW-1:0]        req_addr,
    output logic [LW-1:0]        req_len,
    output logic                 req_sof,
    output logic                 req_eof,
    output logic                 err_count,
    output logic                 err_frame
);

    localparam int WORDS   = DESC_BYTES / 4;
    localparam int WIW     = $clog2(WORDS);
    localparam int DESC_SH = $clog2(DESC_BYTES);
    localparam int EW      = $clog2(MAX_ENT + 1);
    localparam int SW      = $clog2(MAX_FRAME + 1) + 1;

    gather_state_e state_q, state_d;

    logic [IDX_W-1:0]       rd_q;
    logic [WIW-1:0]         wcnt_q;
    logic                   cap_vld_q;
    logic [WIW-1:0]         cap_sel_q;
    logic [EW-1:0]          ent_q;
    logic [EW-1:0]          nent_q;
    logic [SW-1:0]          sum_q;

    logic [WORDS*32-1:0]    desc_flat;
    logic [AW-1:0]          ent_addr;
    logic [LW-1:0]          ent_len;
    logic [CNT_FIELD_W-1:0] cnt_field;

    logic [SW-1:0]          sum_nxt;
    logic                   over;
    logic                   bad_cnt;
    logic                   last_ent;

    // Descriptor capture buffer, written one cycle after each read
    tfd_desc_store #(
        .WORDS (WORDS),
        .IW    (WIW)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_vld_q),
        .wr_sel  (cap_sel_q),
        .wr_data (mem_rdata),
        .flat    (desc_flat)
    );

    // Scatter entry decode and selection
    tfd_entry_mux #(
        .DESC_BITS (WORDS * 32),
        .MAX_ENT   (MAX_ENT),
        .SEL_W     (EW),
        .AW        (AW),
        .LW        (LW)
    ) mux_i (
        .flat      (desc_flat),
        .sel       (ent_q),
        .ent_addr  (ent_addr),
        .ent_len   (ent_len),
        .cnt_field (cnt_field)
    );

    assign sum_nxt  = sum_q + SW'(ent_len);
    assign over     = (sum_nxt > SW'(MAX_FRAME));
    assign bad_cnt  = (cnt_field == '0) || (cnt_field > CNT_FIELD_W'(MAX_ENT));
    assign last_ent = (ent_q == (nent_q - EW'(1)));
    assign rd_idx   = rd_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_q != wr_idx) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (wcnt_q == WIW'(WORDS - 1)) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = bad_cnt ? ST_RETIRE : ST_EMIT;
            end
            ST_EMIT: begin
                if (over) state_d = ST_RETIRE;
                else if (req_ready && last_ent) state_d = ST_RETIRE;
            end
            ST_RETIRE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        req_valid = 1'b0;
        err_count = 1'b0;
        err_frame = 1'b0;
        mem_addr  = {ring_base, {BASE_LSB{1'b0}}}
                  + (AW'(rd_q) << DESC_SH)
                  + (AW'(wcnt_q) << 2);
        req_addr  = ent_addr;
        req_len   = ent_len;
        req_sof   = (ent_q == '0);
        req_eof   = last_ent;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FETCH:  mem_req = 1'b1;
            ST_CHECK:  err_count = bad_cnt;
            ST_EMIT: begin
                req_valid = !over;
                err_frame = over;
            end
            ST_RETIRE: ;
            default:   ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= '0;
            wcnt_q    <= '0;
            cap_vld_q <= 1'b0;
            cap_sel_q <= '0;
            ent_q     <= '0;
            nent_q    <= '0;
            sum_q     <= '0;
        end else begin
            cap_vld_q <= (state_q == ST_FETCH);
            cap_sel_q <= wcnt_q;
            case (state_q)
                ST_IDLE:  wcnt_q <= '0;
                ST_FETCH: wcnt_q <= wcnt_q + WIW'(1);
                ST_CHECK: begin
                    nent_q <= EW'(cnt_field);
                    ent_q  <= '0;
                    sum_q  <= '0;
                end
                ST_EMIT: begin
                    if (!over && req_ready) begin
                        ent_q <= ent_q + EW'(1);
                        sum_q <= sum_nxt;
                    end
                end
                ST_RETIRE: rd_q <= rd_q + IDX_W'(1);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tfd_gather_chk.sv
module tfd_gather_chk #(
    parameter int AW    = 36,
    parameter int IDX_W = 8,
    parameter int LW    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] wr_idx,
    input logic [IDX_W-1:0] rd_idx,
    input logic             mem_req,
    input logic             req_valid,
    input logic             req_ready,
    input logic [AW-1:0]    req_addr,
    input logic [LW-1:0]    req_len,
    input logic             req_sof,
    input logic             req_eof,
    input logic             err_count,
    input logic             err_frame
);

    // R2
    empty_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (rd_idx != wr_idx));

    // R3
    fetch_emit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_valid);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)
                                       && $stable(req_sof) && $stable(req_eof)));

    // R7
    count_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_count |-> (!req_valid && !err_frame));

    // R8
    frame_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |-> !req_valid);

    // R8
    frame_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> !err_frame);

    // R9
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx != $past(rd_idx)) |-> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

    // R9
    eof_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_eof) |=> (!req_valid && $stable(rd_idx)));

endmodule

bind tfd_gather_top tfd_gather_chk #(
    .AW    (AW),
    .IDX_W (IDX_W),
    .LW    (LW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .mem_req   (mem_req),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_sof   (req_sof),
    .req_eof   (req_eof),
    .err_count (err_count),
    .err_frame (err_frame)
);

// File: tb/tfd_gather_top_tb_top.sv
`timescale 1ns/1ps
module tfd_gather_top_tb_top;

    localparam logic [27:0] BASE      = 28'h0ABC123;
    localparam logic [35:0] BASE_BYTE = {BASE, 8'h00};

    typedef struct {
        logic [35:0] a;
        int          l;
        bit          s;
        bit          e;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wr_idx = 8'd0;
    logic [7:0]  rd_idx;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic [31:0] mem_rdata = 32'd0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [35:0] req_addr;
    logic [11:0] req_len;
    logic        req_sof, req_eof, err_count, err_frame;

    logic [7:0]  ring_mem [0:32767];
    exp_t        exq [$];
    int          evq [$];
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          rdy_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          fk = 0;
    int          mem_cycles = 0;
    int          rd_wait = 0;
    logic [7:0]  rd_exp = 8'd0;
    bit          hold_pend = 1'b0;
    logic [35:0] h_a;
    logic [11:0] h_l;
    logic        h_s, h_e;
    logic [31:0] t_lo  [20];
    logic [3:0]  t_hi  [20];
    int          t_len [20];

    always #4 clk = ~clk;

    tfd_gather_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (BASE),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_sof   (req_sof),
        .req_eof   (req_eof),
        .err_count (err_count),
        .err_frame (err_frame)
    );

    // Synchronous memory model
    always @(posedge clk) begin
        if (mem_req) begin
            logic [35:0] off;
            logic [14:0] ix;
            off = mem_addr - BASE_BYTE;
            ix  = off[14:0];
            mem_rdata <= {ring_mem[ix + 15'd3], ring_mem[ix + 15'd2],
                          ring_mem[ix + 15'd1], ring_mem[ix]};
        end
    end

    // Downstream ready pattern
    always @(posedge clk) begin
        #1;
        if (rdy_mode) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req_ready = lfsr[0];
        end else begin
            req_ready = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            bit sched;
            sched = 1'b0;
            if (mem_req) begin
                logic [35:0] ea;
                ea = BASE_BYTE + (36'(rd_idx) << 7) + (36'(fk) << 2);
                chk(mem_addr == ea, "R3 fetch address", 64'(mem_addr), 64'(ea));
                chk(rd_idx != wr_idx, "R2 read from empty ring", 64'(rd_idx), 64'(wr_idx));
                chk(!req_valid, "R3 fetch and emit overlap", 64'(req_valid), 64'd0);
                fk++;
                mem_cycles++;
            end else begin
                fk = 0;
            end
            if (hold_pend) begin
                chk(req_valid && req_addr == h_a && req_len == h_l && req_sof == h_s && req_eof == h_e,
                    "R6 stall hold", {27'd0, req_valid, req_addr}, {28'd1, h_a});
            end
            hold_pend = req_valid && !req_ready;
            h_a = req_addr; h_l = req_len; h_s = req_sof; h_e = req_eof;
            if (req_valid && req_ready) begin
                if (exq.size() == 0) begin
                    chk(1'b0, "R4 unexpected request", 64'(req_addr), 64'd0);
                end else begin
                    exp_t x;
                    x = exq.pop_front();
                    chk(req_addr == x.a, "R4 request address", 64'(req_addr), 64'(x.a));
                    chk(int'(req_len) == x.l, "R4 request length", 64'(req_len), 64'(x.l));
                    chk(req_sof == x.s && req_eof == x.e, "R5 frame markers",
                        {62'd0, req_sof, req_eof}, {62'd0, x.s, x.e});
                end
                if (req_eof) begin
                    int k;
                    k = (evq.size() > 0) ? evq.pop_front() : -1;
                    chk(k == 0, "R5 end of frame event", 64'd0, 64'(k));
                    sched = 1'b1;
                end
            end
            if (err_count) begin
                int k;
                k = (evq.size() > 0) ? evq.pop_front() : -1;
                chk(k == 1, "R7 count error event", 64'd1, 64'(k));
                sched = 1'b1;
            end
            if (err_frame) begin
                int k;
                k = (evq.size() > 0) ? evq.pop_front() : -1;
                chk(k == 2, "R8 frame error event", 64'd2, 64'(k));
                sched = 1'b1;
            end
            if (rd_wait == 1) begin
                chk(rd_idx == rd_exp, "R9 read index advance", 64'(rd_idx), 64'(rd_exp));
            end
            if (rd_wait > 0) rd_wait--;
            if (sched) begin
                rd_wait = 2;
                rd_exp  = rd_idx + 8'd1;
            end
        end
    end

    task automatic gen_ent(input int slot, input int n);
        for (int e = 0; e < n; e++) begin
            t_lo[e]  = 32'h4000_0000 ^ (32'(slot) << 12) ^ (32'(e) << 6) ^ 32'(e * 3);
            t_hi[e]  = 4'((slot + e) % 16);
            t_len[e] = 1 + ((slot * 37 + e * 91) % 400);
        end
    endtask

    task automatic put_desc(input int slot, input logic [7:0] cntb, input int n);
        int b;
        int eff;
        int sum;
        bit ok;
        b = slot * 128;
        for (int i = 0; i < 128; i++) ring_mem[b + i] = 8'hEE;
        ring_mem[b + 0] = 8'hA5;
        ring_mem[b + 1] = 8'h5A;
        ring_mem[b + 2] = 8'hC3;
        ring_mem[b + 3] = cntb;
        for (int e = 0; e < n; e++) begin
            logic [15:0] hw;
            int o;
            o  = b + 4 + 6 * e;
            hw = {12'(t_len[e]), t_hi[e]};
            ring_mem[o + 0] = t_lo[e][7:0];
            ring_mem[o + 1] = t_lo[e][15:8];
            ring_mem[o + 2] = t_lo[e][23:16];
            ring_mem[o + 3] = t_lo[e][31:24];
            ring_mem[o + 4] = hw[7:0];
            ring_mem[o + 5] = hw[15:8];
        end
        for (int i = 124; i < 128; i++) ring_mem[b + i] = 8'h77;
        eff = int'(cntb[4:0]);
        if (eff == 0 || eff > 20) begin
            evq.push_back(1);
        end else begin
            sum = 0;
            ok  = 1'b1;
            for (int e = 0; e < eff; e++) begin
                exp_t x;
                if (sum + t_len[e] > 8192) begin
                    evq.push_back(2);
                    ok = 1'b0;
                    break;
                end
                sum += t_len[e];
                x.a = {t_hi[e], t_lo[e]};
                x.l = t_len[e];
                x.s = (e == 0);
                x.e = (e == eff - 1);
                exq.push_back(x);
            end
            if (ok) evq.push_back(0);
        end
    endtask

    task automatic wait_drain(input logic [7:0] target);
        int cyc;
        cyc = 0;
        while (!(rd_idx == target && exq.size() == 0 && evq.size() == 0) && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (4) @(negedge clk);
        chk(rd_idx == target, "R9 ring drained", 64'(rd_idx), 64'(target));
        chk(exq.size() == 0 && evq.size() == 0, "R4 all expected items seen",
            64'(exq.size() + evq.size()), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog act=hung exp=complete");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 32768; i++) ring_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_idx == 8'd0, "R1 reset rd_idx", 64'(rd_idx), 64'd0);
        chk(!req_valid && !mem_req, "R1 reset outputs", {62'd0, req_valid, mem_req}, 64'd0);
        rst_n = 1'b1;

        // R2 empty ring stays idle
        repeat (20) @(negedge clk);
        chk(mem_cycles == 0, "R2 no fetch while empty", 64'(mem_cycles), 64'd0);

        // Stage A: corner descriptors with ready held high
        gen_ent(0, 3);  put_desc(0, 8'h03, 3);
        gen_ent(1, 2);  put_desc(1, 8'hE2, 2);     // R4 upper count bits ignored
        gen_ent(2, 2);  put_desc(2, 8'h00, 2);     // R7 zero count
        gen_ent(3, 20); put_desc(3, 8'h15, 20);    // R7 count of 21
        gen_ent(4, 3);
        t_len[0] = 4000; t_len[1] = 4000; t_len[2] = 300;
        put_desc(4, 8'h03, 3);                     // R8 overflow at third entry
        gen_ent(5, 3);
        t_len[0] = 4000; t_len[1] = 4000; t_len[2] = 192;
        put_desc(5, 8'h03, 3);                     // R8 exactly at the limit
        gen_ent(6, 20); put_desc(6, 8'h14, 20);    // R4 full twenty entries
        wr_idx = 8'd7;
        wait_drain(8'd7);

        // Stage B: bulk traffic with stalls
        rdy_mode = 1'b1;
        for (int s = 7; s < 250; s++) begin
            gen_ent(s, 1 + (s % 4));
            put_desc(s, 8'(1 + (s % 4)), 1 + (s % 4));
        end
        wr_idx = 8'd250;
        wait_drain(8'd250);

        // Stage C: wrap of the read index through 255 to 0
        for (int s = 250; s < 260; s++) begin
            gen_ent(s % 256, 2);
            put_desc(s % 256, 8'h02, 2);
        end
        wr_idx = 8'd4;
        wait_drain(8'd4);

        mem_cycles = 0;
        repeat (20) @(negedge clk);
        chk(mem_cycles == 0, "R2 idle after wrap", 64'(mem_cycles), 64'd0);

        summary();
        $finish;
    end

endmodule